// File: doc/BRIEF.md
# Dual-Width Bit Reflection Unit

This block is a special function unit that sits on a transport-triggered processor datapath. It reverses the bit order of one operand. It has two modes: a byte mode that reverses the low eight bits, and a word mode that reverses all thirty-two bits. A one-bit opcode that comes with the operand picks the mode.

Writing the operand to the trigger port starts the operation. The result is available on a registered output one clock later. It stays there until the next accepted trigger.

There is no valid/ready pair at the edge. A trigger is a single-cycle load strobe. Back-pressure from the processor comes only through the global lock input: while lock is high, the output register is frozen and a trigger strobe in that cycle is not taken. The interconnect is expected to hold or re-issue any move that it stalls.

Both modes share one fixed cross-wiring network. The byte result is taken from the top eight bits of the word reversal. A multiplexer in front of the output register then selects between the two results.

Top module: `bitrefl_fu`

## Requirements
- R1: A synchronous active-high reset clears the result output to 0x00000000 at the next clock edge.
- R2: Word mode is opcode value 1. In this mode, result bit (31-i) equals operand bit i for every i from 0 to 31.
- R3: Byte mode is opcode value 0. In this mode, result bit (7-i) equals operand bit i for i from 0 to 7, and result bits [31:8] are zero. Operand bits [31:8] have no effect on the result.
- R4: The result of a trigger accepted at a clock edge (load high, lock low) appears on the output right after that same edge, which is exactly one cycle of latency.
- R5: While load is low, the result output keeps its last value, whatever the operand and opcode inputs do.
- R6: While lock is high, the result output does not change, even when load is high. A trigger strobe in a locked cycle is not taken.
- R7: The opcode is sampled only together with an accepted trigger. A later change of opcode does not alter the held result.
- R8: Feeding a result back as a new operand in the same mode returns the original operand. In byte mode the returned value is the original masked to its low eight bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| glock | input | 1 | Global lock; freezes the unit while high |
| trig_data | input | 32 | Operand written to the trigger port |
| trig_load | input | 1 | Trigger strobe; starts an operation |
| trig_op | input | 1 | Mode select: 0 = byte reflection, 1 = word reflection |
| result | output | 32 | Registered reflected result |

## Verification
The bench builds the unit with its default widths: a 32-bit word and an 8-bit byte field. With these widths the full cross-wiring can be checked against a behavioural loop model on every clock. The byte field sits in the top eight bits of the shared network, so corrupted upper operand bits and mis-steered byte bits both show up as mismatches against the model. Random operands in both modes, together with feedback round trips, cover the involution property across the whole bit range.

// File: rtl/bitrefl_pkg.sv
package bitrefl_pkg;
  typedef enum logic {
    OP_REFL_BYTE = 1'b0,
    OP_REFL_WORD = 1'b1
  } refl_op_e;
endpackage

// File: rtl/refl_net.sv
// Fixed cross-wiring: output bit k takes input bit (W-1-k).
module refl_net #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar k = 0; k < W; k++) begin : g_wire
    assign dout[k] = din[W-1-k];
  end
endmodule

// File: rtl/refl_mode_sel.sv
// Picks word result or byte result (top field of word reversal, zero-extended).
module refl_mode_sel
  import bitrefl_pkg::*;
#(
  parameter int W = 32,
  parameter int B = 8
) (
  input  logic [W-1:0] rev_word,
  input  refl_op_e     op,
  output logic [W-1:0] sel_out
);
  localparam int PAD_W = W - B;

  logic [W-1:0] byte_res;
  assign byte_res = {{PAD_W{1'b0}}, rev_word[W-1 -: B]};

  always_comb begin
    if (op == OP_REFL_WORD) sel_out = rev_word;
    else                    sel_out = byte_res;
  end
endmodule

// File: rtl/bitrefl_fu.sv
module bitrefl_fu
  import bitrefl_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              glock,
  input  logic [WORD_W-1:0] trig_data,
  input  logic              trig_load,
  input  logic              trig_op,
  output logic [WORD_W-1:0] result
);
  localparam int HI_W = WORD_W - BYTE_W;

  logic [WORD_W-1:0] rev_word;
  logic [WORD_W-1:0] next_val;
  logic              take;
  refl_op_e          op_e;

  assign op_e = refl_op_e'(trig_op);
  assign take = trig_load && !glock;

  refl_net #(.W(WORD_W)) u_net (
    .din  (trig_data),
    .dout (rev_word)
  );

  refl_mode_sel #(.W(WORD_W), .B(BYTE_W)) u_sel (
    .rev_word (rev_word),
    .op       (op_e),
    .sel_out  (next_val)
  );

  always_ff @(posedge clk) begin
    if (rst)       result <= '0;
    else if (take) result <= next_val;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> result == '0);

  // R5 R6 R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (!$past(trig_load) || $past(glock))) |-> $stable(result));

  // R2 R4
  word_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(take) && $past(trig_op))
      |-> (result[WORD_W-1] == $past(trig_data[0]) &&
           result[0] == $past(trig_data[WORD_W-1])));

  // R3 R4
  byte_field_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(take) && !$past(trig_op))
      |-> (result[WORD_W-1 -: HI_W] == '0 &&
           result[BYTE_W-1] == $past(trig_data[0]) &&
           result[0] == $past(trig_data[BYTE_W-1])));
endmodule

// File: tb/bitrefl_fu_tb_top.sv
`timescale 1ns/1ps
module bitrefl_fu_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        glock = 1'b0;
  logic [31:0] trig_data = '0;
  logic        trig_load = 1'b0;
  logic        trig_op = 1'b0;
  logic [31:0] result;

  int errors = 0;
  int checks = 0;
  logic [31:0] model_q = '0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  bitrefl_fu dut_i (
    .clk(clk), .rst(rst), .glock(glock), .trig_data(trig_data),
    .trig_load(trig_load), .trig_op(trig_op), .result(result)
  );

  function automatic logic [31:0] ref_reflect(logic [31:0] v, logic op);
    logic [31:0] r = '0;
    int n = op ? 32 : 8;
    for (int b = 0; b < n; b++) if (v[b]) r[n-1-b] = 1'b1;
    return r;
  endfunction

  // behavioural reference, updated each edge
  always @(posedge clk) begin
    if (rst) model_q = '0;
    else if (trig_load && !glock) model_q = ref_reflect(trig_data, trig_op);
  end

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", t, act, exp);
    end
  endtask

  // drive one cycle, compare output against model after the edge
  task automatic cyc(logic ld, logic op, logic [31:0] d, logic lk);
    trig_load = ld; trig_op = op; trig_data = d; glock = lk;
    @(posedge clk); @(negedge clk);
    check(tag, result, model_q);
  endtask

  initial begin
    #(200000 * 5.0);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] x, r;
    @(negedge clk);
    tag = "R1";
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0);
    check("R1 reset value", result, 32'h0);
    rst = 1'b0;

    tag = "R2";
    cyc(1'b1, 1'b1, 32'h0000_0001, 1'b0);
    check("R2 R4 word 1", result, 32'h8000_0000);
    cyc(1'b1, 1'b1, 32'h1234_5678, 1'b0);
    check("R2 word pattern", result, 32'h1E6A_2C48);
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b1, $urandom, 1'b0);

    tag = "R3";
    cyc(1'b1, 1'b0, 32'h0000_0001, 1'b0);
    check("R3 byte 1", result, 32'h0000_0080);
    cyc(1'b1, 1'b0, 32'hFFFF_FF01, 1'b0);
    check("R3 upper ignored", result, 32'h0000_0080);
    cyc(1'b1, 1'b0, 32'hABCD_EF80, 1'b0);
    check("R3 byte 80", result, 32'h0000_0001);
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, $urandom, 1'b0);

    tag = "R5";
    cyc(1'b1, 1'b1, 32'h0000_00F0, 1'b0);
    x = result;
    for (int i = 0; i < 5; i++) cyc(1'b0, i[0], $urandom, 1'b0);
    check("R5 R7 hold", result, x);

    tag = "R6";
    for (int i = 0; i < 4; i++) cyc(1'b1, i[0], $urandom, 1'b1);
    check("R6 locked", result, x);
    cyc(1'b1, 1'b0, 32'h0000_0003, 1'b0);
    check("R6 after unlock", result, 32'h0000_00C0);

    tag = "R7";
    cyc(1'b0, 1'b1, 32'h0000_0003, 1'b0);
    check("R7 op change no effect", result, 32'h0000_00C0);

    tag = "R8";
    for (int i = 0; i < 16; i++) begin
      logic op = i[0];
      x = $urandom;
      cyc(1'b1, op, x, 1'b0);
      r = result;
      cyc(1'b1, op, r, 1'b0);
      check("R8 round trip", result, op ? x : {24'h0, x[7:0]});
    end

    tag = "R1";
    trig_load = 1'b1; rst = 1'b1;
    cyc(1'b1, 1'b1, 32'h8000_0000, 1'b0);
    check("R1 mid-run reset", result, 32'h0);
    rst = 1'b0;
    cyc(1'b0, 1'b0, 32'h0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule